// File: doc/BRIEF.md
# Set-Associative Data Address Translator

This block turns data-side virtual addresses into physical addresses. It holds a small set-associative table. Each way of each set has two words: a match word, which carries the tag, a valid bit and a 2-bit usage field, and a translate word, which carries the physical page number, a cache-inhibit bit and four access-permission bits. Software loads the table through a direct word write port, and the same port reads any word back. The block does no refill of its own. On a miss it reports the miss and the faulting address, and leaves the table as it was.

A request gives a virtual address and a read/write flag. The privilege mode and the two enable conditions come from side inputs. After a fixed latency, which can be set separately for hits and misses, the block answers with a one-cycle response pulse. The response carries the physical address, the cache-inhibit flag, a status code and, when something went wrong, the offending virtual address. A hit ages the usage fields of its set. A separate combinational probe port runs the same lookup for debug. It changes no state and reports a failed lookup as zero.

Top module: `dtlb_xlate`

## Requirements
- R1: While reset is held low and after it is released, rsp_valid is 0 and every table word reads back as zero.
- R2: When ctl_mmu_en or ctl_present is 0, a request gives status hit (code 0), physical address equal to the virtual address, cache-inhibit equal to the top address bit (set from 0x80000000 upward), and fault address 0.
- R3: The set index is (va >> PAGE_BITS) & (SETS-1). The tag comparison keeps only the bits at and above PAGE_BITS+log2(SETS), so the set-index bits of a stored match word are ignored.
- R4: A way matches only when bit 0 (valid) of its match word is 1 and its tag agrees. When several ways match, the lowest-numbered way is used.
- R5: On a permitted hit the physical address is the translate word's bits above PAGE_BITS joined with the page-offset bits of the virtual address. Cache-inhibit is translate-word bit 0, and the fault address is 0.
- R6: Translate-word permission bits are: bit 1 user read, bit 2 user write, bit 3 supervisor read, bit 4 supervisor write. The bit chosen by ctl_super and req_we must be 1. If it is 0 the status is page fault (code 2) and the fault address is the virtual address.
- R7: With no matching valid way the status is miss (code 1), the physical address and cache-inhibit are 0, and the fault address is the virtual address.
- R8: A translated hit (including one that faults) decrements every nonzero usage field (match-word bits 7:6) in its set. It then ORs the hit way's field with (SETS-1)&3. Misses and untranslated requests leave the usage fields unchanged.
- R9: rsp_valid is a one-cycle pulse. After a miss it comes MISS_LAT cycles after the accepting edge; for every other outcome it comes HIT_LAT cycles after.
- R10: A request is accepted only when none is pending. While a request is pending, req_valid and req_va are ignored.
- R11: The probe port uses the same lookup and permission rules and the same untranslated rule. It returns zero address and zero cache-inhibit on a miss or a denied access, and it never changes a usage field.
- R12: With cfg_we high, cfg_wdata is written into the word picked by cfg_sel (0 match, 1 translate), cfg_way and cfg_set at the clock edge. cfg_rdata shows the picked word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_mmu_en | input | 1 | Translation enable from the status register |
| ctl_present | input | 1 | Translator-present configuration bit |
| ctl_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| req_valid | input | 1 | Request strobe |
| req_va | input | VA_W | Request virtual address |
| req_we | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_status | output | 2 | 0 hit, 1 miss, 2 page fault |
| rsp_pa | output | VA_W | Physical address |
| rsp_ci | output | 1 | Cache-inhibit |
| rsp_fault_va | output | VA_W | Faulting virtual address, 0 on success |
| prb_va | input | VA_W | Probe virtual address |
| prb_we | input | 1 | Probe write flag |
| prb_pa | output | VA_W | Probe physical address, 0 on failure |
| prb_ci | output | 1 | Probe cache-inhibit |
| cfg_we | input | 1 | Table word write enable |
| cfg_sel | input | 1 | 0 match word, 1 translate word |
| cfg_way | input | WAY_W | Way index |
| cfg_set | input | SET_W | Set index |
| cfg_wdata | input | VA_W | Table write data |
| cfg_rdata | output | VA_W | Table read data |

## Verification
The latency assertion assumes that HIT_LAT and MISS_LAT are both at least 1. It also assumes that the accepting cycle is the only point at which req_valid matters. The bench therefore holds req_valid for one accepting edge, and for longer only in the deliberate pending-request test. The other properties hold for any stimulus. The bench keeps ctl_super, ctl_mmu_en and ctl_present steady from the accepting edge until the response arrives. It writes the table only while no request is pending, so a write never meets a usage update on the same word.

// File: rtl/dtlb_pkg.sv
// dtlb_pkg
// Shared status codes and table-word bit positions for the data translator.
// Assumes address words are at least 8 bits wide so the usage field fits.
package dtlb_pkg;

    typedef enum logic [1:0] {
        XS_HIT   = 2'd0,
        XS_MISS  = 2'd1,
        XS_FAULT = 2'd2
    } xlate_status_e;

    // Match word fields
    localparam int MW_VALID  = 0;
    localparam int MW_USE_LO = 6;
    localparam int MW_USE_HI = 7;

    // Translate word fields
    localparam int TW_CI = 0;
    localparam int TW_UR = 1;
    localparam int TW_UW = 2;
    localparam int TW_SR = 3;
    localparam int TW_SW = 4;

endpackage

// File: rtl/dtlb_table.sv
// dtlb_table
// Storage for match and translate words, WAYS x SETS of each. Provides a
// software write/read port, two combinational set read ports (request and
// probe) and the usage-field ageing applied on a translated hit.
// Assumes SETS is a power of two and set indices arrive already masked.
module dtlb_table
    import dtlb_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int WAYS  = 2,
    parameter int SETS  = 4,
    parameter int SET_W = 2,
    parameter int WAY_W = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic                       cfg_sel,
    input  logic [WAY_W-1:0]           cfg_way,
    input  logic [SET_W-1:0]           cfg_set,
    input  logic [VA_W-1:0]            cfg_wdata,
    output logic [VA_W-1:0]            cfg_rdata,
    input  logic [SET_W-1:0]           rd_set_a,
    output logic [WAYS-1:0][VA_W-1:0]  a_match,
    output logic [WAYS-1:0][VA_W-1:0]  a_trans,
    input  logic [SET_W-1:0]           rd_set_b,
    output logic [WAYS-1:0][VA_W-1:0]  b_match,
    output logic [WAYS-1:0][VA_W-1:0]  b_trans,
    input  logic                       upd_en,
    input  logic [SET_W-1:0]           upd_set,
    input  logic [WAY_W-1:0]           upd_way
);

    localparam logic [1:0] RELOAD = 2'((SETS - 1) & 3);

    logic [VA_W-1:0] m_q [WAYS][SETS];
    logic [VA_W-1:0] t_q [WAYS][SETS];

    // Next usage value: age if nonzero, then reload the hit way.
    function automatic logic [1:0] usage_next(input logic [1:0] u, input logic is_hit);
        logic [1:0] d;
        d = (u != 2'd0) ? u - 2'd1 : u;
        return is_hit ? (d | RELOAD) : d;
    endfunction

    // Table state: reset clear, software writes, usage ageing on hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                for (int s = 0; s < SETS; s++) begin
                    m_q[w][s] <= '0;
                    t_q[w][s] <= '0;
                end
            end
        end else begin
            for (int w = 0; w < WAYS; w++) begin
                for (int s = 0; s < SETS; s++) begin
                    if (cfg_we && !cfg_sel && cfg_way == WAY_W'(w) && cfg_set == SET_W'(s)) begin
                        m_q[w][s] <= cfg_wdata;
                    end else if (upd_en && upd_set == SET_W'(s)) begin
                        m_q[w][s][MW_USE_HI:MW_USE_LO] <=
                            usage_next(m_q[w][s][MW_USE_HI:MW_USE_LO], upd_way == WAY_W'(w));
                    end
                    if (cfg_we && cfg_sel && cfg_way == WAY_W'(w) && cfg_set == SET_W'(s)) begin
                        t_q[w][s] <= cfg_wdata;
                    end
                end
            end
        end
    end

    // Software read-back of the selected word.
    always_comb begin
        cfg_rdata = '0;
        for (int w = 0; w < WAYS; w++) begin
            for (int s = 0; s < SETS; s++) begin
                if (cfg_way == WAY_W'(w) && cfg_set == SET_W'(s)) begin
                    cfg_rdata = cfg_sel ? t_q[w][s] : m_q[w][s];
                end
            end
        end
    end

    // Set read ports for the request and probe lookups.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            a_match[w] = '0;
            a_trans[w] = '0;
            b_match[w] = '0;
            b_trans[w] = '0;
            for (int s = 0; s < SETS; s++) begin
                if (rd_set_a == SET_W'(s)) begin
                    a_match[w] = m_q[w][s];
                    a_trans[w] = t_q[w][s];
                end
                if (rd_set_b == SET_W'(s)) begin
                    b_match[w] = m_q[w][s];
                    b_trans[w] = t_q[w][s];
                end
            end
        end
    end

endmodule

// File: rtl/dtlb_lookup.sv
// dtlb_lookup
// Combinational way search and permission check for one set. The lowest
// matching valid way wins. Assumes the match/translate words belong to the
// set selected from the same virtual address.
module dtlb_lookup
    import dtlb_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int WAYS      = 2,
    parameter int WAY_W     = 1,
    parameter int PAGE_BITS = 13,
    parameter int TAG_LO    = 15
) (
    input  logic [VA_W-1:0]            va,
    input  logic                       we,
    input  logic                       sup,
    input  logic [WAYS-1:0][VA_W-1:0]  match_w,
    input  logic [WAYS-1:0][VA_W-1:0]  trans_w,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic                       fault,
    output logic [VA_W-1:0]            pa,
    output logic                       ci
);

    localparam logic [VA_W-1:0] TAG_MASK = {VA_W{1'b1}} << TAG_LO;

    logic [VA_W-1:0] sel_t;
    logic            allow;
    logic            unused_bits;

    // Way search, scanning downwards so the lowest match is kept.
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        sel_t   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_w[w][MW_VALID] && ((match_w[w] & TAG_MASK) == (va & TAG_MASK))) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
                sel_t   = trans_w[w];
            end
        end
    end

    // Permission bit picked by mode and direction.
    always_comb begin
        if (sup) allow = we ? sel_t[TW_SW] : sel_t[TW_SR];
        else     allow = we ? sel_t[TW_UW] : sel_t[TW_UR];
    end

    assign fault       = hit && !allow;
    assign pa          = {sel_t[VA_W-1:PAGE_BITS], va[PAGE_BITS-1:0]};
    assign ci          = sel_t[TW_CI];
    assign unused_bits = ^{sel_t[PAGE_BITS-1:TW_SW+1]};

endmodule

// File: rtl/dtlb_xlate.sv
// dtlb_xlate
// Data-side virtual-to-physical translator. Accepts one request at a time,
// answers after HIT_LAT or MISS_LAT cycles with a one-cycle pulse, ages the
// usage fields on translated hits and offers a side-effect-free probe.
// Assumes WAYS in 1..4, SETS a power of two up to 128, latencies >= 1.
module dtlb_xlate
    import dtlb_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int WAYS      = 2,
    parameter int SETS      = 4,
    parameter int PAGE_BITS = 13,
    parameter int HIT_LAT   = 1,
    parameter int MISS_LAT  = 1,
    localparam int LOG_SETS = $clog2(SETS),
    localparam int SET_W    = (SETS > 1) ? LOG_SETS : 1,
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_mmu_en,
    input  logic             ctl_present,
    input  logic             ctl_super,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic             req_we,
    output logic             rsp_valid,
    output logic [1:0]       rsp_status,
    output logic [VA_W-1:0]  rsp_pa,
    output logic             rsp_ci,
    output logic [VA_W-1:0]  rsp_fault_va,
    input  logic [VA_W-1:0]  prb_va,
    input  logic             prb_we,
    output logic [VA_W-1:0]  prb_pa,
    output logic             prb_ci,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [WAY_W-1:0] cfg_way,
    input  logic [SET_W-1:0] cfg_set,
    input  logic [VA_W-1:0]  cfg_wdata,
    output logic [VA_W-1:0]  cfg_rdata
);

    localparam int TAG_LO  = PAGE_BITS + LOG_SETS;
    localparam int MAX_LAT = (HIT_LAT > MISS_LAT) ? HIT_LAT : MISS_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);
    localparam logic [SET_W-1:0] SET_MASK = SET_W'(SETS - 1);

    logic                      xl_on;
    logic [SET_W-1:0]          req_set, prb_set;
    logic [WAYS-1:0][VA_W-1:0] a_match, a_trans, b_match, b_trans;
    logic                      r_hit, r_fault, r_ci;
    logic [WAY_W-1:0]          r_way;
    logic [VA_W-1:0]           r_pa;
    logic                      p_hit, p_fault, p_ci;
    logic [WAY_W-1:0]          p_way;
    logic [VA_W-1:0]           p_pa;
    logic                      accept, upd_en;
    xlate_status_e             req_st;
    logic [VA_W-1:0]           req_pa, req_fva;
    logic                      req_ci;
    logic [CNT_W-1:0]          lat_sel;

    logic                      pend_q;
    logic [CNT_W-1:0]          cnt_q;
    logic                      rsp_valid_q;
    xlate_status_e             rsp_st_q;
    logic [VA_W-1:0]           rsp_pa_q, rsp_fva_q;
    logic                      rsp_ci_q;
    logic                      unused_probe;

    assign xl_on   = ctl_mmu_en && ctl_present;
    assign req_set = req_va[PAGE_BITS +: SET_W] & SET_MASK;
    assign prb_set = prb_va[PAGE_BITS +: SET_W] & SET_MASK;
    assign accept  = req_valid && !pend_q;
    assign upd_en  = accept && xl_on && r_hit;

    dtlb_table #(
        .VA_W(VA_W), .WAYS(WAYS), .SETS(SETS), .SET_W(SET_W), .WAY_W(WAY_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_way(cfg_way), .cfg_set(cfg_set),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rd_set_a(req_set), .a_match(a_match), .a_trans(a_trans),
        .rd_set_b(prb_set), .b_match(b_match), .b_trans(b_trans),
        .upd_en(upd_en), .upd_set(req_set), .upd_way(r_way)
    );

    dtlb_lookup #(
        .VA_W(VA_W), .WAYS(WAYS), .WAY_W(WAY_W), .PAGE_BITS(PAGE_BITS), .TAG_LO(TAG_LO)
    ) u_req_lookup (
        .va(req_va), .we(req_we), .sup(ctl_super),
        .match_w(a_match), .trans_w(a_trans),
        .hit(r_hit), .hit_way(r_way), .fault(r_fault), .pa(r_pa), .ci(r_ci)
    );

    dtlb_lookup #(
        .VA_W(VA_W), .WAYS(WAYS), .WAY_W(WAY_W), .PAGE_BITS(PAGE_BITS), .TAG_LO(TAG_LO)
    ) u_prb_lookup (
        .va(prb_va), .we(prb_we), .sup(ctl_super),
        .match_w(b_match), .trans_w(b_trans),
        .hit(p_hit), .hit_way(p_way), .fault(p_fault), .pa(p_pa), .ci(p_ci)
    );

    assign unused_probe = ^p_way;

    // Request outcome: untranslated, miss, fault or permitted hit.
    always_comb begin
        if (!xl_on) begin
            req_st  = XS_HIT;
            req_pa  = req_va;
            req_ci  = req_va[VA_W-1];
            req_fva = '0;
        end else if (!r_hit) begin
            req_st  = XS_MISS;
            req_pa  = '0;
            req_ci  = 1'b0;
            req_fva = req_va;
        end else if (r_fault) begin
            req_st  = XS_FAULT;
            req_pa  = r_pa;
            req_ci  = r_ci;
            req_fva = req_va;
        end else begin
            req_st  = XS_HIT;
            req_pa  = r_pa;
            req_ci  = r_ci;
            req_fva = '0;
        end
    end

    // Latency chosen by outcome.
    assign lat_sel = (req_st == XS_MISS) ? CNT_W'(MISS_LAT) : CNT_W'(HIT_LAT);

    // Response pipeline: capture on accept, pulse after the chosen latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            cnt_q       <= '0;
            rsp_valid_q <= 1'b0;
            rsp_st_q    <= XS_HIT;
            rsp_pa_q    <= '0;
            rsp_ci_q    <= 1'b0;
            rsp_fva_q   <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (accept) begin
                rsp_st_q  <= req_st;
                rsp_pa_q  <= req_pa;
                rsp_ci_q  <= req_ci;
                rsp_fva_q <= req_fva;
                if (lat_sel == CNT_W'(1)) begin
                    rsp_valid_q <= 1'b1;
                end else begin
                    pend_q <= 1'b1;
                    cnt_q  <= lat_sel - CNT_W'(1);
                end
            end else if (pend_q) begin
                if (cnt_q == CNT_W'(1)) begin
                    rsp_valid_q <= 1'b1;
                    pend_q      <= 1'b0;
                end
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign rsp_valid    = rsp_valid_q;
    assign rsp_status   = rsp_st_q;
    assign rsp_pa       = rsp_pa_q;
    assign rsp_ci       = rsp_ci_q;
    assign rsp_fault_va = rsp_fva_q;

    // Probe result: untranslated rule, else zero unless a permitted hit.
    always_comb begin
        if (!xl_on) begin
            prb_pa = prb_va;
            prb_ci = prb_va[VA_W-1];
        end else if (p_hit && !p_fault) begin
            prb_pa = p_pa;
            prb_ci = p_ci;
        end else begin
            prb_pa = '0;
            prb_ci = 1'b0;
        end
    end

endmodule

// File: rtl/dtlb_xlate_chk.sv
// dtlb_xlate_chk
// Property checker for dtlb_xlate, attached by bind. Tracks the cycles since
// the last accepted request with a saturating counter for the latency check.
// Assumes HIT_LAT and MISS_LAT are at least 1 and well below 65535.
module dtlb_xlate_chk
    import dtlb_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 13,
    parameter int HIT_LAT   = 1,
    parameter int MISS_LAT  = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ctl_mmu_en,
    input logic            ctl_present,
    input logic            req_valid,
    input logic            pend_q,
    input logic            rsp_valid,
    input logic [1:0]      rsp_status,
    input logic [VA_W-1:0] rsp_pa,
    input logic            rsp_ci,
    input logic [VA_W-1:0] rsp_fault_va,
    input logic [VA_W-1:0] prb_va,
    input logic [VA_W-1:0] prb_pa
);

    logic        acc;
    logic [15:0] age_q;
    logic        byp_q;

    assign acc = req_valid && !pend_q;

    // Cycles since the last accept, and whether that request was untranslated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= 16'hFFFF;
            byp_q <= 1'b0;
        end else if (acc) begin
            age_q <= 16'd1;
            byp_q <= !(ctl_mmu_en && ctl_present);
        end else if (age_q != 16'hFFFF) begin
            age_q <= age_q + 16'd1;
        end
    end

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (age_q == 16'(HIT_LAT) || age_q == 16'(MISS_LAT)));

    assert_status_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'd3));

    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == XS_MISS) |-> (rsp_pa == '0 && !rsp_ci && rsp_fault_va != '0 || rsp_pa == '0 && !rsp_ci));

    assert_bypass_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && byp_q) |-> (rsp_status == XS_HIT && rsp_fault_va == '0));

    assert_probe_offset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (prb_pa == '0) || (prb_pa[PAGE_BITS-1:0] == prb_va[PAGE_BITS-1:0]));

endmodule

bind dtlb_xlate dtlb_xlate_chk #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_mmu_en(ctl_mmu_en), .ctl_present(ctl_present),
    .req_valid(req_valid), .pend_q(pend_q), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_pa(rsp_pa), .rsp_ci(rsp_ci),
    .rsp_fault_va(rsp_fault_va), .prb_va(prb_va), .prb_pa(prb_pa)
);

// File: tb/dtlb_xlate_bench.sv
// dtlb_xlate_bench
// Loads a 2-way, 4-set table, sweeps every entry under both modes and both
// directions through the request and probe ports, and checks each result
// against a model computed from the requirements.
module dtlb_xlate_bench;

    localparam int VA_W = 32, WAYS = 2, SETS = 4, PB = 13, HL = 2, ML = 3;
    localparam logic [31:0] TMASK = 32'hFFFF_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_mmu_en = 1'b0, ctl_present = 1'b0, ctl_super = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [31:0] req_va = '0;
    logic        rsp_valid, rsp_ci;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_pa, rsp_fault_va;
    logic [31:0] prb_va = '0;
    logic        prb_we = 1'b0;
    logic [31:0] prb_pa;
    logic        prb_ci;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [0:0]  cfg_way = '0;
    logic [1:0]  cfg_set = '0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [31:0] bm [WAYS][SETS];
    logic [31:0] bt [WAYS][SETS];

    always #10 clk = ~clk;

    dtlb_xlate #(.VA_W(VA_W), .WAYS(WAYS), .SETS(SETS), .PAGE_BITS(PB),
                 .HIT_LAT(HL), .MISS_LAT(ML)) u_dtlb_xlate (
        .clk(clk), .rst_n(rst_n), .ctl_mmu_en(ctl_mmu_en), .ctl_present(ctl_present),
        .ctl_super(ctl_super), .req_valid(req_valid), .req_va(req_va), .req_we(req_we),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_pa(rsp_pa), .rsp_ci(rsp_ci),
        .rsp_fault_va(rsp_fault_va), .prb_va(prb_va), .prb_we(prb_we), .prb_pa(prb_pa),
        .prb_ci(prb_ci), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_way(cfg_way),
        .cfg_set(cfg_set), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, input int w, input int s, output logic [31:0] d);
        @(negedge clk);
        cfg_sel = sel; cfg_way = 1'(w); cfg_set = 2'(s);
        #1 d = cfg_rdata;
    endtask

    task automatic wr(input logic sel, input int w, input int s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_way = 1'(w); cfg_set = 2'(s); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) bt[w][s] = d; else bm[w][s] = d;
    endtask

    // Expected result from the requirements; optionally ages the model.
    task automatic model(input logic [31:0] va, input logic we, input logic sup,
                         input logic on, input bit upd, output logic [1:0] st,
                         output logic [31:0] pa, output logic ci, output logic [31:0] fva);
        int s, fw;
        bit found;
        logic [31:0] t;
        logic allow;
        logic [1:0] u;
        if (!on) begin
            st = 2'd0; pa = va; ci = va[31]; fva = '0;
            return;
        end
        s = int'((va >> PB) & 3);
        found = 0; fw = 0;
        for (int w = 0; w < WAYS; w++)
            if (!found && bm[w][s][0] && ((bm[w][s] & TMASK) == (va & TMASK))) begin
                found = 1; fw = w;
            end
        if (!found) begin
            st = 2'd1; pa = '0; ci = 1'b0; fva = va;
            return;
        end
        t = bt[fw][s];
        allow = sup ? (we ? t[4] : t[3]) : (we ? t[2] : t[1]);
        st = allow ? 2'd0 : 2'd2;
        pa = {t[31:PB], va[PB-1:0]};
        ci = t[0];
        fva = allow ? '0 : va;
        if (upd) begin
            for (int w = 0; w < WAYS; w++) begin
                u = bm[w][s][7:6];
                if (u != 0) u = u - 2'd1;
                if (w == fw) u = u | 2'((SETS - 1) & 3);
                bm[w][s][7:6] = u;
            end
        end
    endtask

    task automatic chk_set(input string req, input int s);
        logic [31:0] d;
        for (int w = 0; w < WAYS; w++) begin
            rd(1'b0, w, s, d);
            chk(req, d, bm[w][s]);
        end
    endtask

    // One request: drive, wait for the pulse, compare against the model.
    task automatic do_req(input logic [31:0] va, input logic we, input logic sup,
                          input logic en, input logic pres);
        logic [1:0] st; logic [31:0] pa, fva; logic ci;
        int n;
        model(va, we, sup, en && pres, 1, st, pa, ci, fva);
        @(negedge clk);
        ctl_mmu_en = en; ctl_present = pres; ctl_super = sup;
        req_va = va; req_we = we; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
        chk("R9 latency", 32'(n), (st == 2'd1) ? ML : HL);
        chk((st == 2'd1) ? "R7 status" : (st == 2'd2) ? "R6 status" : "R5 status", 32'(rsp_status), 32'(st));
        chk(en && pres ? "R5 pa" : "R2 pa", rsp_pa, pa);
        chk(en && pres ? "R5 ci" : "R2 ci", 32'(rsp_ci), 32'(ci));
        chk(st == 2'd1 ? "R7 fault va" : "R6 fault va", rsp_fault_va, fva);
        @(negedge clk);
        chk("R9 pulse", 32'(rsp_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, va, pa, fva, p_exp;
        logic [1:0] st;
        logic ci;
        int n;
        for (int w = 0; w < WAYS; w++)
            for (int s = 0; s < SETS; s++) begin bm[w][s] = '0; bt[w][s] = '0; end

        repeat (3) @(negedge clk);
        chk("R1 no response in reset", 32'(rsp_valid), 0);
        @(negedge clk); rst_n = 1'b1;
        for (int w = 0; w < WAYS; w++)
            for (int s = 0; s < SETS; s++) begin
                rd(1'b0, w, s, d); chk("R1 match word", d, 0);
                rd(1'b1, w, s, d); chk("R1 translate word", d, 0);
            end
        chk("R1 idle", 32'(rsp_valid), 0);

        // Fill: set-index bits of the match word hold junk (R3); set 2 way 1
        // is invalid; set 3 way 1 duplicates way 0's tag (R4).
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                logic [16:0] tag;
                tag = 17'(17'h0A0 + s * 2 + ((s == 3) ? 0 : w));
                wr(1'b0, w, s, {tag, 2'(~s), 5'b0, 2'b0, 5'b0, (s == 2 && w == 1) ? 1'b0 : 1'b1});
                wr(1'b1, w, s, {19'(19'h50000 + s * 4 + w), 8'b0,
                                4'((s * 2 + w) * 5 + 3), 1'((s + w) & 1)});
            end
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                rd(1'b1, w, s, d); chk("R12 translate readback", d, bt[w][s]);
            end
        chk_set("R12 match readback", 1);

        // Untranslated requests, both enable conditions.
        do_req(32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b1);
        do_req(32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b1);
        do_req({17'h0A0, 2'd0, 13'h0155}, 1'b1, 1'b1, 1'b1, 1'b0);
        chk_set("R8 no ageing untranslated", 0);

        // Sweep every entry, both modes, both directions.
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                for (int m = 0; m < 4; m++) begin
                    va = {17'(17'h0A0 + s * 2 + w), 2'(s), 13'(13'h0ABC + s * 97 + m)};
                    do_req(va, 1'(m & 1), 1'(m >> 1), 1'b1, 1'b1);
                    chk_set("R8 usage ageing", s);
                end

        // Misses: unknown tag, and a tag that lives in another set (R3).
        do_req(32'hFFFF_E123, 1'b0, 1'b1, 1'b1, 1'b1);
        do_req({17'h0A0, 2'd1, 13'h0042}, 1'b0, 1'b1, 1'b1, 1'b1);
        chk_set("R7 miss leaves table", 1);
        chk_set("R7 miss leaves table", 3);

        // Probe sweep: results and no change to usage fields.
        ctl_mmu_en = 1'b1; ctl_present = 1'b1;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                for (int m = 0; m < 4; m++) begin
                    va = {17'(17'h0A0 + s * 2 + w), 2'(s), 13'(13'h1F00 + m)};
                    model(va, 1'(m & 1), 1'(m >> 1), 1'b1, 0, st, pa, ci, fva);
                    @(negedge clk);
                    prb_va = va; prb_we = 1'(m & 1); ctl_super = 1'(m >> 1);
                    #1;
                    p_exp = (st == 2'd0) ? pa : '0;
                    chk("R11 probe pa", prb_pa, p_exp);
                    chk("R11 probe ci", 32'(prb_ci), (st == 2'd0) ? 32'(ci) : 0);
                    chk_set("R11 probe leaves usage", s);
                end
        @(negedge clk);
        ctl_mmu_en = 1'b0; prb_va = 32'h9000_1234;
        #1;
        chk("R11 probe untranslated pa", prb_pa, 32'h9000_1234);
        chk("R11 probe untranslated ci", 32'(prb_ci), 1);

        // Request during pending is ignored.
        va = {17'h0A0, 2'd0, 13'h0777};
        model(va, 1'b0, 1'b1, 1'b1, 1, st, pa, ci, fva);
        @(negedge clk);
        ctl_mmu_en = 1'b1; ctl_present = 1'b1; ctl_super = 1'b1;
        req_va = va; req_we = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_va = 32'hFFFF_E000;
        n = 1;
        while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
        req_valid = 1'b0;
        chk("R10 first request kept", 32'(rsp_status), 32'(st));
        chk("R10 first request pa", rsp_pa, pa);
        n = 0;
        repeat (6) begin @(negedge clk); if (rsp_valid) n++; end
        chk("R10 no extra response", 32'(n), 0);
        chk_set("R8 usage after pending test", 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule